// File: doc/BRIEF.md
# Bus Ownership Arbiter with Hold Handshake and Pulsed Request/Grant Channels

This block decides which party drives the system bus: the processor's own bus sequencer or an external master. In single-master configuration (`mode_max` low) a DMA controller raises a level request, and the block answers with a level acknowledge for as long as the request is held. In multi-master configuration (`mode_max` high) the hold pins are not used. Instead, each of `NCH` request/grant channels carries a three-pulse exchange on one shared active-low line. The external master pulses the line to ask for the bus. The block pulses the same line to grant it. A further pulse from the master hands the bus back.

Ownership changes only when the sequencer reports a bus-cycle boundary. No change is made while the lock condition is present. While any external master owns the bus, and for one clock after it gives the bus back, `bus_float` stays high so that the sequencer tristates its address, data and strobe drivers. Only one external master owns the bus at a time. A request that arrives during another grant is remembered and served after the bus returns. When several channels are waiting, the lowest channel index wins.

Top module: `bus_own_arbiter`

## Requirements
- R1: During and after reset, `hold_ack` is 0, `rg_pull` is all zeros and `bus_float` is 0.
- R2: With `mode_max`=0, `cycle_boundary`=1 and `lock_active`=0, a high `hold_req` at a clock edge makes `hold_ack` and `bus_float` go high after that edge.
- R3: `hold_ack` rises only after an edge at which `hold_req` was high and `mode_max` was 0. With `mode_max`=1, `hold_req` is ignored.
- R4: No new ownership is granted at an edge where `lock_active`=1. A blocked request is not lost: a pending channel request is served once the lock clears. Lock does not revoke a grant already given.
- R5: Ownership is granted only at an edge where `cycle_boundary`=1.
- R6: After `hold_req` falls, `hold_ack` drops at the next edge while `bus_float` stays high. `bus_float` drops one edge later.
- R7: With `mode_max`=1, a one-clock low on `rg_line_n[i]` is followed by a one-clock high on `rg_pull[i]`. The grant pulse starts at the second edge after the request was sampled, provided the grant is not blocked. `rg_pull[i]`=1 means the block pulls line i low.
- R8: When several channels request at the same edge, the lowest index is granted first. Higher-index channels stay pending.
- R9: While channel i owns the bus, a one-clock low on `rg_line_n[i]` returns the bus. `bus_float` stays high for the clock after the release is sampled and is 0 one edge later.
- R10: `bus_float` is high whenever `hold_ack` is high or any `rg_pull` bit is high. At most one `rg_pull` bit is high at a time.
- R11: A request from another channel during a grant waits. Its grant pulse follows one idle clock after the bus is returned.
- R12: With `mode_max`=0, pulses on `rg_line_n` are ignored and never produce a later grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_max | input | 1 | 1 = pulsed request/grant channels, 0 = hold handshake |
| cycle_boundary | input | 1 | Sequencer is idle or finishing a bus cycle |
| lock_active | input | 1 | Locked sequence in progress; no new grant |
| hold_req | input | 1 | Level bus request from the DMA controller |
| hold_ack | output | 1 | Level acknowledge to the DMA controller |
| rg_line_n | input | NCH | Sampled level of each shared request/grant line, active low |
| rg_pull | output | NCH | Per-channel enable to pull the shared line low (grant pulse) |
| bus_float | output | 1 | Sequencer must tristate all bus outputs |

## Verification
The hardest situation to reach from the ports is a channel request that is held pending across another master's complete tenure and is then served after the return. It needs a correctly timed grant, a cross-channel pulse during ownership and a release pulse, all in order. The bench reaches it with directed sequences of simultaneous pulses and of a mid-tenure pulse. Before these, it runs a sweep over every combination of mode, lock, boundary and request source. Each blocked request is then unblocked, which shows whether it was remembered or rightly discarded.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [2:0] {
    ARB_IDLE   = 3'd0,
    ARB_HOLD   = 3'd1,
    ARB_RG_GNT = 3'd2,
    ARB_RG_OWN = 3'd3,
    ARB_RETAKE = 3'd4
  } arb_state_e;
endpackage

// File: rtl/rg_chan_tracker.sv
module rg_chan_tracker (
  input  logic clk,
  input  logic rst,
  input  logic mode_max,
  input  logic line_n,
  input  logic chan_busy,
  input  logic grant_clr,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)
      pend <= 1'b0;
    else if (grant_clr)
      pend <= 1'b0;
    else if (mode_max && !line_n && !chan_busy)
      pend <= 1'b1;
  end

  // R12
  pend_min_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode_max) && !$past(pend)) |-> !pend);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import bus_arb_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_max,
  input  logic           cycle_boundary,
  input  logic           lock_active,
  input  logic           hold_req,
  input  logic [NCH-1:0] rg_line_n,
  input  logic [NCH-1:0] pend,
  output logic [NCH-1:0] grant_clr,
  output logic [NCH-1:0] chan_busy,
  output logic           hold_ack,
  output logic [NCH-1:0] rg_pull,
  output logic           bus_float
);
  arb_state_e state_q, state_d;
  logic [CW-1:0] owner_q, owner_d, pick;
  logic          may_grant;

  assign may_grant = cycle_boundary && !lock_active;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) pick = CW'(i);
  end

  always_comb begin
    state_d   = state_q;
    owner_d   = owner_q;
    grant_clr = '0;
    case (state_q)
      ARB_IDLE: begin
        if (may_grant) begin
          if (mode_max && (|pend)) begin
            state_d         = ARB_RG_GNT;
            owner_d         = pick;
            grant_clr[pick] = 1'b1;
          end else if (!mode_max && hold_req) begin
            state_d = ARB_HOLD;
          end
        end
      end
      ARB_HOLD:   if (!hold_req) state_d = ARB_RETAKE;
      ARB_RG_GNT: state_d = ARB_RG_OWN;
      ARB_RG_OWN: if (!rg_line_n[owner_q]) state_d = ARB_RETAKE;
      default:    state_d = ARB_IDLE;
    endcase
  end

  always_comb begin
    chan_busy = '0;
    if (state_q == ARB_RG_GNT || state_q == ARB_RG_OWN)
      chan_busy[owner_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ARB_IDLE;
      owner_q   <= '0;
      hold_ack  <= 1'b0;
      rg_pull   <= '0;
      bus_float <= 1'b0;
    end else begin
      state_q   <= state_d;
      owner_q   <= owner_d;
      hold_ack  <= (state_d == ARB_HOLD);
      bus_float <= (state_d != ARB_IDLE);
      rg_pull   <= '0;
      if (state_d == ARB_RG_GNT) rg_pull[owner_d] <= 1'b1;
    end
  end

  // R5
  grant_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_float) |-> $past(cycle_boundary));
  // R4
  grant_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_float) |-> !$past(lock_active));
  // R3
  hold_ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> ($past(hold_req) && !$past(mode_max)));
  // R6
  hold_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && !hold_req) |=> (!hold_ack && bus_float));
  // R10
  float_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_ack || (|rg_pull)) |-> bus_float);
  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rg_pull) && !(hold_ack && (|rg_pull)));
  // R7
  grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|rg_pull) |=> !(|rg_pull));
endmodule

// File: rtl/bus_own_arbiter.sv
module bus_own_arbiter #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_max,
  input  logic           cycle_boundary,
  input  logic           lock_active,
  input  logic           hold_req,
  output logic           hold_ack,
  input  logic [NCH-1:0] rg_line_n,
  output logic [NCH-1:0] rg_pull,
  output logic           bus_float
);
  logic [NCH-1:0] pend, grant_clr, chan_busy;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    rg_chan_tracker u_trk (
      .clk       (clk),
      .rst       (rst),
      .mode_max  (mode_max),
      .line_n    (rg_line_n[g]),
      .chan_busy (chan_busy[g]),
      .grant_clr (grant_clr[g]),
      .pend      (pend[g])
    );
  end

  arb_fsm #(.NCH(NCH)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .mode_max       (mode_max),
    .cycle_boundary (cycle_boundary),
    .lock_active    (lock_active),
    .hold_req       (hold_req),
    .rg_line_n      (rg_line_n),
    .pend           (pend),
    .grant_clr      (grant_clr),
    .chan_busy      (chan_busy),
    .hold_ack       (hold_ack),
    .rg_pull        (rg_pull),
    .bus_float      (bus_float)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!hold_ack && !(|rg_pull) && !bus_float));
endmodule

// File: tb/bus_own_arbiter_bench.sv
module bus_own_arbiter_bench;
  localparam int PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_max = 1'b0, cycle_boundary = 1'b1, lock_active = 1'b0, hold_req = 1'b0;
  logic [NCH-1:0] rg_line_n = '1;
  logic hold_ack, bus_float;
  logic [NCH-1:0] rg_pull;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  bus_own_arbiter #(.NCH(NCH)) u_bus_own_arbiter (
    .clk(clk), .rst(rst), .mode_max(mode_max), .cycle_boundary(cycle_boundary),
    .lock_active(lock_active), .hold_req(hold_req), .hold_ack(hold_ack),
    .rg_line_n(rg_line_n), .rg_pull(rg_pull), .bus_float(bus_float));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic pulse(input int ch);
    rg_line_n[ch] = 1'b0;
    nxt();
    rg_line_n[ch] = 1'b1;
  endtask

  initial begin
    repeat (3) nxt();
    chk("R1 hold_ack", hold_ack, 0);
    chk("R1 rg_pull", rg_pull, 0);
    chk("R1 bus_float", bus_float, 0);
    rst = 1'b0;
    nxt();
    chk("R1 float after reset", bus_float, 0);

    // Sweep: mode x lock x boundary x source (0 = hold, 1.. = channel)
    for (int m = 0; m < 2; m++)
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 2; b++)
          for (int s = 0; s <= NCH; s++) begin
            int g;
            mode_max = m[0]; lock_active = l[0]; cycle_boundary = b[0];
            if (s == 0) begin
              g = (m == 0 && l == 0 && b == 1) ? 1 : 0;
              hold_req = 1'b1;
              nxt(); nxt();
              chk("R2/R3/R4/R5 hold_ack sweep", hold_ack, g);
              chk("R10 float with hold", bus_float, g);
              hold_req = 1'b0;
              lock_active = 1'b0; cycle_boundary = 1'b1;
              nxt();
              chk("R6 hold_ack drop", hold_ack, 0);
              chk("R6 float kept", bus_float, g);
              nxt();
              chk("R6 float released", bus_float, 0);
            end else begin
              int ch = s - 1;
              g = (m == 1 && l == 0 && b == 1) ? 1 : 0;
              pulse(ch);
              nxt();
              chk("R7/R4/R5 grant sweep", rg_pull[ch], g);
              if (g == 0) begin
                lock_active = 1'b0; cycle_boundary = 1'b1;
                nxt();
                chk("R4/R12 deferred grant", rg_pull[ch], m);
              end
              if (m == 1) begin
                nxt();
                chk("R7 grant one clock", rg_pull, 0);
                chk("R10 float while owned", bus_float, 1);
                lock_active = 1'b1;
                nxt();
                chk("R4 lock keeps owner", bus_float, 1);
                lock_active = 1'b0;
                pulse(ch);
                chk("R9 float after release", bus_float, 1);
                nxt();
                chk("R9 float returned", bus_float, 0);
              end else begin
                chk("R12 no float", bus_float, 0);
              end
            end
            nxt();
          end

    // R8 simultaneous requests, then R11 pending served after return
    mode_max = 1'b1; lock_active = 1'b0; cycle_boundary = 1'b1;
    rg_line_n = '0;
    nxt();
    rg_line_n = '1;
    nxt();
    chk("R8 lower channel first", rg_pull, 1);
    nxt();
    chk("R8 pull ends", rg_pull, 0);
    pulse(0);
    chk("R9 float held", bus_float, 1);
    nxt();
    chk("R11 idle gap", bus_float, 0);
    nxt();
    chk("R11 waiting channel granted", rg_pull, 2);
    nxt();
    pulse(1);
    nxt();
    chk("R11 bus returned", bus_float, 0);

    // R11 request on channel 0 during channel 1 tenure
    pulse(1);
    nxt();
    chk("R7 ch1 grant", rg_pull, 2);
    nxt();
    pulse(0);
    nxt();
    chk("R11 no preemption", rg_pull, 0);
    chk("R11 still floated", bus_float, 1);
    pulse(1);
    nxt();
    nxt();
    chk("R11 ch0 after return", rg_pull, 1);
    nxt();
    pulse(0);
    nxt();
    chk("R9 final return", bus_float, 0);

    // R3 hold ignored in channel mode
    hold_req = 1'b1;
    nxt(); nxt();
    chk("R3 hold ignored in channel mode", hold_ack, 0);
    chk("R3 no float", bus_float, 0);
    hold_req = 1'b0;
    nxt();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule